// File: doc/BRIEF.md
# PWM Control Input Acceptance and Termination

This block conditions one control input of a PWM generator, typically a fault line, and decides when that input becomes active and when it is released. The input is chosen from a bank of candidate lines and passed through a polarity stage. It can optionally be resampled only at the PWM end of cycle. It is then gated by a selectable acceptance qualifier. Six acceptance behaviours are available: level, rising edge, either edge, and three latched variants built on a set/reset latch whose winner on a tie is programmable. A latched input is released by a selectable termination event that is gated by its own qualifier. The release can take effect at once or be held until the next end-of-cycle strobe.

A single software bit can be steered into the input path, the acceptance qualifier or the termination qualifier. A bypass switch ignores all local logic and passes through the accepted state of a neighbouring generator. The whole setup comes from one 32-bit configuration word. Its layout is the packed struct `cfg_t` in the package, with fields from the most significant bit down: source index (6), input invert, input resample, acceptance mode (3), reset-wins, acceptance qualifier select (3), acceptance qualifier invert, termination qualifier select (3), termination qualifier invert, termination select (3), termination invert, immediate termination, software bit, software route (2), bypass enable, bypass select (3).

Top module: `ctlin_gate`

## Requirements
- R1: A synchronous active-high reset clears all internal state. `active_o` reads 0 after a reset edge, even while the selected source is high.
- R2: With acceptance mode 000 (level), `active_o` equals the gated input one clock edge later.
- R3: With acceptance mode 001, `active_o` is high for exactly one cycle after the edge at which the gated input is first seen high following a low.
- R4: With acceptance mode 010, `active_o` pulses high for one cycle after every change of the gated input, rising or falling.
- R5: The conditioned source is the line `src_i[index]` XOR the input invert bit. An index at or above NUM_SRC yields 0 before inversion. The gated input is the conditioned source AND the acceptance qualifier. The qualifier select works as follows: 000 gives a constant 1 whatever its invert bit; 001 selects `duty_i`; 010 selects `blank_i`; 011 selects `gen_trig_i`; 100, 101 and 110 select `aux_i[0]`, `aux_i[1]` and `aux_i[2]`; 111 selects the software bit. For any select other than 000, the qualifier invert bit is applied.
- R6: Modes 011, 100 and 101 drive `active_o` from a latch. Mode 011 sets it while the gated input is high, 100 sets it on a rising edge, and 101 sets it on either edge. The latch holds until a termination. Termination select 000 takes a one-cycle `sw_term_i` strobe as the event.
- R7: With the immediate-termination bit at 1, a termination clears the latch at the same edge. With the bit at 0, the termination is remembered and clears the latch at the first edge where `eoc_i` is high, which may be the edge of the event itself.
- R8: When set and reset meet in the same cycle, the latch ends up set if reset-wins is 0 and clear if reset-wins is 1.
- R9: Termination select 001 fires when the conditioned source goes from 1 to 0.
- R10: Termination selects 010, 011 and 100 take `trig_i[0]`, `trig_i[1]` and `trig_i[2]`. Selects 101, 110 and 111 take `aux_i[0..2]` XOR the termination invert bit, which is ignored for selects below 101. An event counts only while the termination qualifier is 1; this qualifier uses the same select encoding as R5 with its own invert bit.
- R11: Software route 00 ORs the software bit into the conditioned source. Route 01 ORs it into the acceptance qualifier after inversion, and route 10 ORs it into the termination qualifier after inversion. Route 11 connects it nowhere. The OR has no effect when the qualifier select is 000.
- R12: With the input resample bit set, the raw source is captured only at edges where `eoc_i` is high. The captured value is used in every cycle, including the cycle of the capturing edge, which still sees the previous capture.
- R13: With bypass enabled, `active_o` equals `peer_active_i[sel]` combinationally. It is 0 when the bypass select is at or above NUM_GEN.
- R14: Acceptance modes 110 and 111 keep `active_o` at 0 one edge after they are selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_i | input | 32 | Configuration word, layout `cfg_t` |
| src_i | input | NUM_SRC | Candidate control input lines |
| duty_i | input | 1 | Duty-cycle-active qualifier |
| blank_i | input | 1 | Blanking-active qualifier |
| gen_trig_i | input | 1 | Generator-triggered qualifier |
| aux_i | input | 3 | Auxiliary lines for qualifiers and termination |
| trig_i | input | 3 | Trigger events A, B, C |
| eoc_i | input | 1 | PWM end-of-cycle strobe |
| sw_term_i | input | 1 | One-cycle software termination strobe |
| peer_active_i | input | NUM_GEN | Accepted state of neighbouring generators |
| active_o | output | 1 | Override request to the PWM generator |

## Verification
Every local result is registered, so a change on the inputs applied between two rising edges shows on `active_o` just after the next rising edge. The only exception is the bypass path, which is combinational and settles within the cycle itself. Termination in synchronised mode is due after the first edge with `eoc_i` high, and a resampled source is due one edge after the capturing strobe. The driver therefore places each expected value in the scoreboard together with the stimulus, on the assumption that it is due after the following rising edge. The monitor compares it at the next falling edge, and multi-cycle behaviours are checked as a chain of such single-edge expectations.

// File: rtl/ctlin_pkg.sv
package ctlin_pkg;

    localparam int SRC_SEL_W = 6;
    localparam int AUX_N     = 3;
    localparam int TRIG_N    = 3;

    typedef enum logic [2:0] {
        ACC_LEVEL      = 3'd0,
        ACC_RISE       = 3'd1,
        ACC_ANY        = 3'd2,
        ACC_LATCH      = 3'd3,
        ACC_LATCH_RISE = 3'd4,
        ACC_LATCH_ANY  = 3'd5,
        ACC_RSV6       = 3'd6,
        ACC_RSV7       = 3'd7
    } acc_mode_e;

    typedef enum logic [2:0] {
        TRM_SOFT   = 3'd0,
        TRM_AUTO   = 3'd1,
        TRM_TRIG_A = 3'd2,
        TRM_TRIG_B = 3'd3,
        TRM_TRIG_C = 3'd4,
        TRM_AUX0   = 3'd5,
        TRM_AUX1   = 3'd6,
        TRM_AUX2   = 3'd7
    } term_sel_e;

    typedef enum logic [1:0] {
        SWR_ACCEPT = 2'd0,
        SWR_AQUAL  = 2'd1,
        SWR_TQUAL  = 2'd2,
        SWR_OFF    = 2'd3
    } sw_route_e;

    typedef struct packed {
        logic [SRC_SEL_W-1:0] src_sel;
        logic                 in_inv;
        logic                 in_sync;
        acc_mode_e            acc_mode;
        logic                 rst_wins;
        logic [2:0]           aq_sel;
        logic                 aq_inv;
        logic [2:0]           tq_sel;
        logic                 tq_inv;
        term_sel_e            term_sel;
        logic                 term_inv;
        logic                 term_now;
        logic                 sw_val;
        sw_route_e            sw_route;
        logic                 byp_en;
        logic [2:0]           byp_sel;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef struct packed {
        logic             duty;
        logic             blank;
        logic             trig;
        logic [AUX_N-1:0] aux;
    } qual_src_t;

    // Qualifier mux shared by acceptance and termination paths.
    function automatic logic qual_pick(input logic [2:0] sel, input logic inv,
                                       input qual_src_t s, input logic sw_bit,
                                       input logic sw_here);
        logic raw;
        case (sel)
            3'd1:    raw = s.duty;
            3'd2:    raw = s.blank;
            3'd3:    raw = s.trig;
            3'd4:    raw = s.aux[0];
            3'd5:    raw = s.aux[1];
            3'd6:    raw = s.aux[2];
            default: raw = sw_bit;
        endcase
        if (sel == 3'd0) return 1'b1;
        return (raw ^ inv) | sw_here;
    endfunction

    function automatic logic is_latched(input acc_mode_e m);
        return (m == ACC_LATCH) || (m == ACC_LATCH_RISE) || (m == ACC_LATCH_ANY);
    endfunction

endpackage

// File: rtl/ctlin_cond.sv
module ctlin_cond
    import ctlin_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [SRC_SEL_W-1:0] src_sel,
    input  logic                 in_inv,
    input  logic                 in_sync,
    input  logic [2:0]           aq_sel,
    input  logic                 aq_inv,
    input  logic [2:0]           tq_sel,
    input  logic                 tq_inv,
    input  logic                 sw_val,
    input  sw_route_e            sw_route,
    input  logic [NUM_SRC-1:0]   src_i,
    input  qual_src_t            qs,
    input  logic                 eoc_i,
    output logic                 src_c,
    output logic                 acc_in,
    output logic                 tq_ok
);

    logic raw;
    logic held_q;
    logic pre;
    logic aq_ok;

    always_comb begin
        raw = 1'b0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (src_sel == SRC_SEL_W'(k)) raw = src_i[k];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)      held_q <= 1'b0;
        else if (eoc_i) held_q <= raw;
    end

    assign pre    = in_sync ? held_q : raw;
    assign src_c  = (pre ^ in_inv) | (sw_val && (sw_route == SWR_ACCEPT));
    assign aq_ok  = qual_pick(aq_sel, aq_inv, qs, sw_val, sw_val && (sw_route == SWR_AQUAL));
    assign tq_ok  = qual_pick(tq_sel, tq_inv, qs, sw_val, sw_val && (sw_route == SWR_TQUAL));
    assign acc_in = src_c & aq_ok;

endmodule

// File: rtl/ctlin_term.sv
module ctlin_term
    import ctlin_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  term_sel_e         term_sel,
    input  logic              term_inv,
    input  logic              term_now,
    input  logic              src_c,
    input  logic              tq_ok,
    input  logic              sw_term_i,
    input  logic [TRIG_N-1:0] trig_i,
    input  logic [AUX_N-1:0]  aux_i,
    input  logic              eoc_i,
    output logic              latch_rst
);

    logic src_prev_q;
    logic pend_q;
    logic ev;
    logic ev_ok;

    always_comb begin
        ev = 1'b0;
        case (term_sel)
            TRM_SOFT:   ev = sw_term_i;
            TRM_AUTO:   ev = src_prev_q & ~src_c;
            TRM_TRIG_A: ev = trig_i[0];
            TRM_TRIG_B: ev = trig_i[1];
            TRM_TRIG_C: ev = trig_i[2];
            TRM_AUX0:   ev = aux_i[0] ^ term_inv;
            TRM_AUX1:   ev = aux_i[1] ^ term_inv;
            TRM_AUX2:   ev = aux_i[2] ^ term_inv;
        endcase
    end

    assign ev_ok     = ev & tq_ok;
    assign latch_rst = term_now ? ev_ok : (eoc_i & (pend_q | ev_ok));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            src_prev_q <= 1'b0;
            pend_q     <= 1'b0;
        end else begin
            src_prev_q <= src_c;
            pend_q     <= (!term_now && !eoc_i) ? (pend_q | ev_ok) : 1'b0;
        end
    end

endmodule

// File: rtl/ctlin_accept.sv
module ctlin_accept
    import ctlin_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  acc_mode_e acc_mode,
    input  logic      rst_wins,
    input  logic      acc_in,
    input  logic      latch_rst,
    output logic      active_q,
    output logic      latch_q,
    output logic      latch_set
);

    logic prev_q;
    logic rise;
    logic any_edge;
    logic latch_d;
    logic act_d;

    assign rise     = acc_in & ~prev_q;
    assign any_edge = acc_in ^ prev_q;

    always_comb begin
        latch_set = 1'b0;
        case (acc_mode)
            ACC_LATCH:      latch_set = acc_in;
            ACC_LATCH_RISE: latch_set = rise;
            ACC_LATCH_ANY:  latch_set = any_edge;
            default:        latch_set = 1'b0;
        endcase
    end

    always_comb begin
        if (!is_latched(acc_mode)) latch_d = 1'b0;
        else if (rst_wins)         latch_d = ~latch_rst & (latch_set | latch_q);
        else                       latch_d = latch_set | (latch_q & ~latch_rst);
    end

    always_comb begin
        case (acc_mode)
            ACC_LEVEL: act_d = acc_in;
            ACC_RISE:  act_d = rise;
            ACC_ANY:   act_d = any_edge;
            ACC_LATCH, ACC_LATCH_RISE, ACC_LATCH_ANY: act_d = latch_d;
            default:   act_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_q   <= 1'b0;
            latch_q  <= 1'b0;
            active_q <= 1'b0;
        end else begin
            prev_q   <= acc_in;
            latch_q  <= latch_d;
            active_q <= act_d;
        end
    end

endmodule

// File: rtl/ctlin_gate.sv
module ctlin_gate
    import ctlin_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int NUM_GEN = 4
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [31:0]        cfg_i,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               duty_i,
    input  logic               blank_i,
    input  logic               gen_trig_i,
    input  logic [2:0]         aux_i,
    input  logic [2:0]         trig_i,
    input  logic               eoc_i,
    input  logic               sw_term_i,
    input  logic [NUM_GEN-1:0] peer_active_i,
    output logic               active_o
);

    cfg_t      cfg;
    qual_src_t qs;
    logic      src_c;
    logic      acc_in;
    logic      tq_ok;
    logic      latch_rst;
    logic      latch_set;
    logic      latch_q;
    logic      active_q;
    logic      peer_pick;

    assign cfg = cfg_t'(cfg_i);
    assign qs  = '{duty: duty_i, blank: blank_i, trig: gen_trig_i, aux: aux_i};

    ctlin_cond #(.NUM_SRC(NUM_SRC)) u_cond (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .src_sel  (cfg.src_sel),
        .in_inv   (cfg.in_inv),
        .in_sync  (cfg.in_sync),
        .aq_sel   (cfg.aq_sel),
        .aq_inv   (cfg.aq_inv),
        .tq_sel   (cfg.tq_sel),
        .tq_inv   (cfg.tq_inv),
        .sw_val   (cfg.sw_val),
        .sw_route (cfg.sw_route),
        .src_i    (src_i),
        .qs       (qs),
        .eoc_i    (eoc_i),
        .src_c    (src_c),
        .acc_in   (acc_in),
        .tq_ok    (tq_ok)
    );

    ctlin_term u_term (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .term_sel  (cfg.term_sel),
        .term_inv  (cfg.term_inv),
        .term_now  (cfg.term_now),
        .src_c     (src_c),
        .tq_ok     (tq_ok),
        .sw_term_i (sw_term_i),
        .trig_i    (trig_i),
        .aux_i     (aux_i),
        .eoc_i     (eoc_i),
        .latch_rst (latch_rst)
    );

    ctlin_accept u_accept (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .acc_mode  (cfg.acc_mode),
        .rst_wins  (cfg.rst_wins),
        .acc_in    (acc_in),
        .latch_rst (latch_rst),
        .active_q  (active_q),
        .latch_q   (latch_q),
        .latch_set (latch_set)
    );

    always_comb begin
        peer_pick = 1'b0;
        for (int g = 0; g < NUM_GEN; g++) begin
            if (cfg.byp_sel == 3'(g)) peer_pick = peer_active_i[g];
        end
    end

    assign active_o = cfg.byp_en ? peer_pick : active_q;

endmodule

// File: rtl/ctlin_gate_chk.sv
module ctlin_gate_chk
    import ctlin_pkg::*;
#(
    parameter int NUM_GEN = 4
) (
    input logic      clk_i,
    input logic      rst_i,
    input logic      eoc_i,
    input acc_mode_e acc_mode,
    input logic      rst_wins,
    input logic      term_now,
    input logic      byp_en,
    input logic [2:0] byp_sel,
    input logic      active_o,
    input logic      active_q,
    input logic      latch_q,
    input logic      latch_set,
    input logic      latch_rst
);

    logic latched;
    logic reserved;
    assign latched  = is_latched(acc_mode);
    assign reserved = (acc_mode == ACC_RSV6) || (acc_mode == ACC_RSV7);

    assert_rise_single_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_mode == ACC_RISE && $past(acc_mode == ACC_RISE) && active_q) |=> !active_q)
        else $error("rising-mode output held longer than one cycle");

    assert_sync_term_at_eoc_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        latch_rst |-> (term_now || eoc_i))
        else $error("synchronised termination outside end of cycle");

    assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (latched && !rst_wins && latch_set) |=> latch_q)
        else $error("set lost against reset in set-dominant latch");

    assert_reset_wins_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (latched && rst_wins && latch_rst) |=> !latch_q)
        else $error("reset lost against set in reset-dominant latch");

    assert_bypass_absent_R13: assert property (@(posedge clk_i) disable iff (rst_i)
        (byp_en && (int'(byp_sel) >= NUM_GEN)) |-> !active_o)
        else $error("bypass of absent generator not zero");

    assert_reserved_idle_R14: assert property (@(posedge clk_i) disable iff (rst_i)
        (!byp_en && reserved) |=> (byp_en || !active_o))
        else $error("reserved acceptance mode produced activity");

endmodule

bind ctlin_gate ctlin_gate_chk #(.NUM_GEN(NUM_GEN)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .eoc_i     (eoc_i),
    .acc_mode  (cfg.acc_mode),
    .rst_wins  (cfg.rst_wins),
    .term_now  (cfg.term_now),
    .byp_en    (cfg.byp_en),
    .byp_sel   (cfg.byp_sel),
    .active_o  (active_o),
    .active_q  (active_q),
    .latch_q   (latch_q),
    .latch_set (latch_set),
    .latch_rst (latch_rst)
);

// File: tb/tb_ctlin_gate.sv
module tb_ctlin_gate;
    import ctlin_pkg::*;

    localparam int NUM_SRC = 8;
    localparam int NUM_GEN = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst;
    cfg_t               c;
    logic [31:0]        cfg_w;
    logic [NUM_SRC-1:0] src;
    logic               duty, blank, gtrig, eoc, swt;
    logic [2:0]         aux, trig;
    logic [NUM_GEN-1:0] peer;
    logic               active;

    assign cfg_w = c;

    ctlin_gate #(.NUM_SRC(NUM_SRC), .NUM_GEN(NUM_GEN)) dut (
        .clk_i         (clk),
        .rst_i         (rst),
        .cfg_i         (cfg_w),
        .src_i         (src),
        .duty_i        (duty),
        .blank_i       (blank),
        .gen_trig_i    (gtrig),
        .aux_i         (aux),
        .trig_i        (trig),
        .eoc_i         (eoc),
        .sw_term_i     (swt),
        .peer_active_i (peer),
        .active_o      (active)
    );

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t sb[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    // Driver: the expectation holds after the coming rising edge.
    task automatic step(input logic e, input string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        #2;
    endtask

    // Monitor: compares at the falling edge after the expected rising edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_cmp++;
            if (active !== it.exp) begin
                n_bad++;
                $display("FAIL %s: active_o=%0b expected %0b", it.tag, active, it.exp);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        c = '0; src = '0; duty = 0; blank = 0; gtrig = 0; eoc = 0; swt = 0;
        aux = '0; trig = '0; peer = '0; rst = 1'b1;
        @(negedge clk); #2;
        src[0] = 1'b1;
        step(1'b0, "R1 reset holds output low");
        step(1'b0, "R1 reset holds output low (2)");
        rst = 1'b0; src = '0;
        step(1'b0, "R1 idle after reset");

        // R2 level
        src[0] = 1'b1; step(1'b1, "R2 level follows high");
        step(1'b1, "R2 level stays high");
        src[0] = 1'b0; step(1'b0, "R2 level follows low");

        // R3 rising
        c.acc_mode = ACC_RISE;
        src[0] = 1'b1; step(1'b1, "R3 rising pulse");
        step(1'b0, "R3 pulse lasts one cycle");
        src[0] = 1'b0; step(1'b0, "R3 no pulse on fall");

        // R4 any edge
        c.acc_mode = ACC_ANY;
        src[0] = 1'b1; step(1'b1, "R4 pulse on rise");
        step(1'b0, "R4 quiet while steady");
        src[0] = 1'b0; step(1'b1, "R4 pulse on fall");
        step(1'b0, "R4 quiet after fall");

        // R5 qualifier, polarity, source selection
        c.acc_mode = ACC_LEVEL; c.aq_sel = 3'd1;
        src[0] = 1'b1; duty = 1'b0; step(1'b0, "R5 duty qualifier blocks");
        duty = 1'b1; step(1'b1, "R5 duty qualifier passes");
        c.aq_inv = 1'b1; step(1'b0, "R5 inverted qualifier blocks");
        duty = 1'b0; step(1'b1, "R5 inverted qualifier passes");
        c.aq_sel = 3'd0; c.aq_inv = 1'b0; src = '0; step(1'b0, "R5 back to idle");
        c.in_inv = 1'b1; step(1'b1, "R5 input inversion");
        c.in_inv = 1'b0; step(1'b0, "R5 inversion removed");
        src = '1; c.src_sel = 6'd9; step(1'b0, "R5 out-of-range index gives 0");
        c.src_sel = 6'd3; step(1'b1, "R5 line 3 selected");
        src = '0; c.src_sel = 6'd0; step(1'b0, "R5 cleanup");

        // R6 latched level, manual terminate, immediate
        c.acc_mode = ACC_LATCH; c.term_now = 1'b1; c.term_sel = TRM_SOFT;
        src[0] = 1'b1; step(1'b1, "R6 latch set");
        src[0] = 1'b0; step(1'b1, "R6 latch holds after source drops");
        step(1'b1, "R6 latch still holds");
        swt = 1'b1; step(1'b0, "R6 software terminate clears");
        swt = 1'b0; step(1'b0, "R6 stays clear");

        // R7 terminate synchronised to end of cycle
        c.term_now = 1'b0;
        src[0] = 1'b1; step(1'b1, "R7 latch set");
        src[0] = 1'b0; step(1'b1, "R7 hold");
        swt = 1'b1; step(1'b1, "R7 termination pending");
        swt = 1'b0; step(1'b1, "R7 still waiting for end of cycle");
        eoc = 1'b1; step(1'b0, "R7 cleared at end of cycle");
        eoc = 1'b0; step(1'b0, "R7 stays clear");

        // R8 dominance
        c.term_now = 1'b1; c.rst_wins = 1'b0;
        src[0] = 1'b1; step(1'b1, "R8 latch set");
        swt = 1'b1; step(1'b1, "R8 set wins tie");
        c.rst_wins = 1'b1; step(1'b0, "R8 reset wins tie");
        swt = 1'b0; step(1'b1, "R8 set again after tie");
        src[0] = 1'b0; step(1'b1, "R8 hold");
        swt = 1'b1; step(1'b0, "R8 plain reset");
        swt = 1'b0; c.rst_wins = 1'b0; step(1'b0, "R8 stays clear");

        // R9 auto termination on falling source
        c.acc_mode = ACC_LATCH_RISE; c.term_sel = TRM_AUTO;
        src[0] = 1'b1; step(1'b1, "R9 latch set on rise");
        step(1'b1, "R9 hold while source high");
        src[0] = 1'b0; step(1'b0, "R9 terminated by source fall");
        step(1'b0, "R9 stays clear");

        // R6 latched on either edge
        c.acc_mode = ACC_LATCH_ANY; c.term_sel = TRM_SOFT;
        src[0] = 1'b1; step(1'b1, "R6 any-edge latch set on rise");
        swt = 1'b1; step(1'b0, "R6 any-edge latch cleared");
        swt = 1'b0; src[0] = 1'b0; step(1'b1, "R6 any-edge latch set on fall");
        swt = 1'b1; step(1'b0, "R6 any-edge latch cleared again");
        swt = 1'b0; step(1'b0, "R6 stays clear");

        // R10 trigger termination with qualifier, aux with inversion
        c.acc_mode = ACC_LATCH; c.term_sel = TRM_TRIG_A; c.tq_sel = 3'd2;
        src[0] = 1'b1; step(1'b1, "R10 latch set");
        src[0] = 1'b0; step(1'b1, "R10 hold");
        trig = 3'b001; blank = 1'b0; step(1'b1, "R10 termination qualifier blocks trigger");
        blank = 1'b1; step(1'b0, "R10 trigger A terminates");
        trig = '0; blank = 1'b0; step(1'b0, "R10 stays clear");
        aux = 3'b001; c.term_sel = TRM_AUX0; c.term_inv = 1'b1; c.tq_sel = 3'd0;
        src[0] = 1'b1; step(1'b1, "R10 latch set");
        src[0] = 1'b0; step(1'b1, "R10 inverted aux high means no event");
        aux = 3'b000; step(1'b0, "R10 inverted aux low terminates");
        c.term_sel = TRM_SOFT; c.term_inv = 1'b0; step(1'b0, "R10 cleanup");

        // R11 software bit routing
        c.acc_mode = ACC_LEVEL; c.sw_route = SWR_ACCEPT; c.sw_val = 1'b1;
        step(1'b1, "R11 software bit drives acceptance");
        c.sw_route = SWR_AQUAL; c.aq_sel = 3'd1; duty = 1'b0; src[0] = 1'b1;
        step(1'b1, "R11 software bit opens acceptance qualifier");
        c.sw_val = 1'b0; step(1'b0, "R11 qualifier closed without software bit");
        c.aq_sel = 3'd0; src[0] = 1'b0;
        c.acc_mode = ACC_LATCH; c.term_now = 1'b1; c.sw_route = SWR_TQUAL; c.tq_sel = 3'd2;
        src[0] = 1'b1; step(1'b1, "R11 latch set");
        src[0] = 1'b0; step(1'b1, "R11 hold");
        swt = 1'b1; step(1'b1, "R11 termination qualifier closed");
        c.sw_val = 1'b1; step(1'b0, "R11 software bit opens termination qualifier");
        swt = 1'b0; c.sw_val = 1'b0; c.sw_route = SWR_ACCEPT; c.tq_sel = 3'd0;
        c.acc_mode = ACC_LEVEL; step(1'b0, "R11 cleanup");

        // R12 resample at end of cycle
        c.in_sync = 1'b1; eoc = 1'b1; src[0] = 1'b0; step(1'b0, "R12 capture low");
        eoc = 1'b0; src[0] = 1'b1; step(1'b0, "R12 source not sampled");
        eoc = 1'b1; step(1'b0, "R12 capturing edge uses previous value");
        eoc = 1'b0; src[0] = 1'b0; step(1'b1, "R12 captured high used");
        step(1'b1, "R12 held between strobes");
        eoc = 1'b1; step(1'b1, "R12 old value at capture edge");
        eoc = 1'b0; step(1'b0, "R12 captured low used");
        c.in_sync = 1'b0;

        // R13 bypass
        c.byp_en = 1'b1; c.byp_sel = 3'd2; peer = 4'b0100; step(1'b1, "R13 bypass follows peer 2");
        peer = 4'b0000; step(1'b0, "R13 bypass follows peer low");
        c.byp_sel = 3'd5; peer = 4'b1111; step(1'b0, "R13 absent peer gives 0");
        c.byp_sel = 3'd3; step(1'b1, "R13 bypass follows peer 3");
        c.byp_en = 1'b0; peer = '0; step(1'b0, "R13 bypass off");

        // R14 reserved modes
        c.acc_mode = ACC_RSV6; src[0] = 1'b1; step(1'b0, "R14 mode 110 idle");
        step(1'b0, "R14 mode 110 stays idle");
        c.acc_mode = ACC_RSV7; step(1'b0, "R14 mode 111 idle");
        c.acc_mode = ACC_LEVEL; src[0] = 1'b0; step(1'b0, "R14 cleanup");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule